// File: doc/BRIEF.md
# SPI Flash Command Engine

This block runs one serial-flash transaction at a time on behalf of software that reaches it through a small byte-wide register port. A transaction has three parts: an opcode byte, then a programmable number of outbound bytes, then a programmable number of inbound bytes. The opcode sits in a register of its own. The outbound bytes and the captured inbound bytes share one eight-slot buffer. Software reaches that buffer through a single data port whose slot pointer advances on every access, wraps, can be read back and can be rewound.

Software uses it in a fixed order. It loads the byte counts and the opcode. It rewinds the pointer and pushes the outbound bytes. It rewinds again and starts the run. It polls the busy bit until the run ends. Then it rewinds, skips past its own outbound bytes and reads the response. The serial side is SPI mode 0, most significant bit first, with chip select held low for the whole transaction. The serial clock comes from the system clock through a divider set by a two-bit speed field.

Top module: `spi_cmd_engine`

## Requirements
- R1: The opcode register sits at offset 0x0 and reads back as written. On every run the opcode is the first byte on MOSI, and it never takes a buffer slot.
- R2: The count register sits at offset 0x1. It holds the inbound byte count in bits 7:4 and the outbound byte count in bits 3:0. It reads back as written and a run does not change it.
- R3: At offset 0x2, writing 1 to bit 4 sets the buffer pointer to zero, and writing 1 to bit 0 starts a run. On a read of this offset, bit 0 is 1 while a run is active and every other bit is 0.
- R4: A read or a write at offset 0xC reaches the buffer slot at the current pointer and then adds one to the pointer, modulo 8. The pointer reads back in bits 2:0 of offset 0xD.
- R5: During a run, chip select stays low for exactly 1 + W + R bytes of 8 clock pulses each, where W and R are the two counts. Data is sent most significant bit first: MOSI changes only while SCLK is low, and MISO is sampled on the rising edge. SCLK stays low whenever chip select is high.
- R6: Outbound bytes come from consecutive buffer slots, starting at the pointer value when the run starts. During inbound bytes MOSI sends 0x00. Captured bytes go into the slots that follow the last outbound slot.
- R7: When W is 0, the first captured byte is thrown away. At the end of a run the pointer equals its start value plus W plus R, minus one when W is 0 and R is nonzero, all modulo 8.
- R8: Bits 5:4 of offset 0xD are the speed code. Codes 1, 2 and 3 give an SCLK high time of DIV_UNIT x (code + 1) system clocks. The reserved code 0 behaves like code 3. After reset the code is 3.
- R9: While a run is active, writes to offsets 0x0, 0x1, 0x2, 0xC and 0xD change nothing, and reads of 0xC do not move the pointer.
- R10: After reset the opcode and count registers read 0x00, offset 0x2 reads 0x00, offset 0xD reads 0x30, chip select is high and SCLK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe; a read of the data port moves the pointer |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, valid in the same cycle |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench sweeps outbound counts 0 to 3 against inbound counts 0 to 4, and each run uses a different speed code, including the reserved one. Its slave model sends a distinct byte in every wire position. A run with no outbound bytes shows whether the first captured byte is dropped and whether the pointer lands one short. Runs with outbound bytes show whether the response is stored right after the outbound data. Each slot's contents are compared against both the outbound pattern and the slave's byte sequence, so a swapped order, a lost byte or an off-by-one pointer each give a different mismatch. One run writes to every writable register and reads the data port while busy, and then checks that the counts, the pointer and the buffer contents are unchanged.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam logic [3:0] OFF_OPCODE = 4'h0;
    localparam logic [3:0] OFF_COUNT  = 4'h1;
    localparam logic [3:0] OFF_CTRL   = 4'h2;
    localparam logic [3:0] OFF_DATA   = 4'hC;
    localparam logic [3:0] OFF_STAT   = 4'hD;

    localparam int CTRL_GO_BIT     = 0;
    localparam int CTRL_REWIND_BIT = 4;

    localparam logic [1:0] SPEED_RESET = 2'd3;
endpackage

// File: rtl/spi_buf_mem.sv
module spi_buf_mem #(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] slots_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots_q[waddr] <= wdata;
    end

    assign rdata = slots_q[raddr];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       tx_byte,
    input  logic [DIV_W-1:0] half_cnt,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             done,
    output logic [7:0]       rx_byte
);
    typedef struct packed {
        logic             active;
        logic             sclk;
        logic [2:0]       bit_idx;
        logic [DIV_W-1:0] div;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic             done;
    } shift_t;

    shift_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.active  = 1'b1;
            d.sclk    = 1'b0;
            d.bit_idx = '0;
            d.div     = '0;
            d.sh      = tx_byte;
        end else if (q.active) begin
            if (q.div == half_cnt - 1'b1) begin
                d.div = '0;
                if (!q.sclk) begin
                    d.sclk = 1'b1;
                    d.rx   = {q.rx[6:0], miso};
                end else begin
                    d.sclk = 1'b0;
                    if (q.bit_idx == 3'd7) begin
                        d.active = 1'b0;
                        d.done   = 1'b1;
                    end else begin
                        d.bit_idx = q.bit_idx + 3'd1;
                        d.sh      = {q.sh[6:0], 1'b0};
                    end
                end
            end else begin
                d.div = q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk    = q.sclk;
    assign mosi    = q.sh[7];
    assign done    = q.done;
    assign rx_byte = q.rx;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int DIV_UNIT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int AW    = $clog2(DEPTH);
    localparam int DIV_W = $clog2(DIV_UNIT * 4 + 1);

    typedef struct packed {
        logic [7:0]    opcode;
        logic [7:0]    count;
        logic [1:0]    speed;
        logic [AW-1:0] ptr;
        logic          active;
        logic [4:0]    idx;
        logic          start;
        logic [7:0]    tx;
    } eng_t;

    eng_t q, d;

    logic          buf_we;
    logic [7:0]    buf_wdata;
    logic [7:0]    buf_rdata;
    logic          sh_done;
    logic [7:0]    sh_rx;
    logic [DIV_W-1:0] half_cnt;
    logic [1:0]    speed_eff;
    logic [3:0]    wr_n, rd_n;
    logic [4:0]    total;
    logic          in_read, drop_first;

    assign wr_n      = q.count[3:0];
    assign rd_n      = q.count[7:4];
    assign total     = 5'd1 + {1'b0, wr_n} + {1'b0, rd_n};
    assign in_read   = q.idx > {1'b0, wr_n};
    assign drop_first = (wr_n == 4'd0) && (q.idx == 5'd1);
    assign speed_eff = (q.speed == 2'd0) ? 2'd3 : q.speed;
    assign half_cnt  = DIV_W'(DIV_UNIT * (int'(speed_eff) + 1));

    always_comb begin
        d         = q;
        d.start   = 1'b0;
        buf_we    = 1'b0;
        buf_wdata = reg_wdata;
        if (!q.active) begin
            if (reg_wr) begin
                case (reg_addr)
                    OFF_OPCODE: d.opcode = reg_wdata;
                    OFF_COUNT:  d.count  = reg_wdata;
                    OFF_STAT:   d.speed  = reg_wdata[5:4];
                    OFF_DATA: begin
                        buf_we = 1'b1;
                        d.ptr  = q.ptr + 1'b1;
                    end
                    OFF_CTRL: begin
                        if (reg_wdata[CTRL_REWIND_BIT]) d.ptr = '0;
                        if (reg_wdata[CTRL_GO_BIT]) begin
                            d.active = 1'b1;
                            d.idx    = '0;
                            d.start  = 1'b1;
                            d.tx     = q.opcode;
                        end
                    end
                    default: ;
                endcase
            end else if (reg_rd && reg_addr == OFF_DATA) begin
                d.ptr = q.ptr + 1'b1;
            end
        end else if (sh_done) begin
            if (in_read && !drop_first) begin
                buf_we    = 1'b1;
                buf_wdata = sh_rx;
                d.ptr     = q.ptr + 1'b1;
            end
            if (q.idx + 5'd1 < total) begin
                d.idx   = q.idx + 5'd1;
                d.start = 1'b1;
                if (q.idx < {1'b0, wr_n}) begin
                    d.tx  = buf_rdata;
                    d.ptr = q.ptr + 1'b1;
                end else begin
                    d.tx = 8'h00;
                end
            end else begin
                d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.speed <= SPEED_RESET;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            OFF_OPCODE: reg_rdata = q.opcode;
            OFF_COUNT:  reg_rdata = q.count;
            OFF_CTRL:   reg_rdata = {7'd0, q.active};
            OFF_DATA:   reg_rdata = buf_rdata;
            OFF_STAT:   reg_rdata = {2'b00, q.speed, 1'b0, 3'(q.ptr)};
            default:    reg_rdata = 8'h00;
        endcase
    end

    spi_buf_mem #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (q.ptr),
        .wdata (buf_wdata),
        .raddr (q.ptr),
        .rdata (buf_rdata)
    );

    spi_byte_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (q.start),
        .tx_byte  (q.tx),
        .half_cnt (half_cnt),
        .miso     (spi_miso),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .done     (sh_done),
        .rx_byte  (sh_rx)
    );

    assign spi_cs_n = !q.active;

    logic          busy_w;
    logic [7:0]    count_w;
    logic [AW-1:0] ptr_w;
    assign busy_w  = q.active;
    assign count_w = q.count;
    assign ptr_w   = q.ptr;
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    reg_addr,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [7:0]    reg_wdata,
    input logic          spi_cs_n,
    input logic          spi_sclk,
    input logic          busy,
    input logic [7:0]    count,
    input logic [AW-1:0] ptr
);
    // R5
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R5
    edge_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> !spi_cs_n);

    // R9
    count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(count)));

    // R3
    go_starts_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'h2 && reg_wdata[0] && !busy) |=> (busy && !spi_cs_n));

    // R4
    ptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !reg_wr && !reg_rd) |=> $stable(ptr));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .busy      (busy_w),
    .count     (count_w),
    .ptr       (ptr_w)
);

// File: tb/spi_cmd_engine_test.sv
`timescale 1ns/1ps
module spi_cmd_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    function automatic logic [7:0] resp(int n);
        return 8'((n * 29 + 90) & 255);
    endfunction

    function automatic logic [7:0] wpat(int i, int w, int r);
        return 8'(((i + 1) * 17) ^ (w * 64 + r * 5));
    endfunction

    // slave model
    int   bitn = 0;
    logic [7:0] mlog [32];
    logic [7:0] cur;
    realtime t_rise = 0;
    int   half_meas = 0;

    always @(negedge spi_cs_n) begin
        bitn = 0;
        cur  = 8'h00;
    end
    always @(posedge spi_sclk) begin
        t_rise = $realtime;
        cur = {cur[6:0], spi_mosi};
        if ((bitn % 8) == 7 && (bitn / 8) < 32) mlog[bitn / 8] = cur;
        bitn = bitn + 1;
    end
    always @(negedge spi_sclk) half_meas = int'(($realtime - t_rise) / 4.0);

    assign spi_miso = resp(bitn / 8)[7 - (bitn % 8)];

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        s = 8'h01;
        while (s[0]) rd(4'h2, s);
    endtask

    task automatic run(int w, int r, int spd, bit poke);
        logic [7:0] v;
        logic [7:0] opc;
        int exp_ptr;
        opc = 8'(8'h9F ^ (w * 16 + r));
        wr(4'h1, 8'(r * 16 + w));
        wr(4'h0, opc);
        wr(4'h2, 8'h10);
        for (int i = 0; i < w; i++) wr(4'hC, wpat(i, w, r));
        rd(4'hD, v);
        check("R4 pointer after pushes", v[2:0], w % 8);
        wr(4'h2, 8'h10);
        wr(4'hD, 8'(spd * 16));
        wr(4'h2, 8'h01);
        rd(4'h2, v);
        check("R3 busy bit", v, 8'h01);
        if (poke) begin
            wr(4'h1, 8'hFF);
            wr(4'h0, 8'h00);
            wr(4'hC, 8'hEE);
            wr(4'hD, 8'h00);
            wr(4'h2, 8'h10);
            rd(4'hC, v);
        end
        wait_idle();
        check("R5 bytes on wire", bitn, 8 * (1 + w + r));
        check("R1 opcode first", mlog[0], opc);
        for (int i = 0; i < w; i++) check("R6 outbound byte", mlog[1 + i], wpat(i, w, r));
        for (int j = 0; j < r; j++) check("R6 zero fill", mlog[1 + w + j], 8'h00);
        check("R8 sclk high time", half_meas, ((spd == 0) ? 3 : spd) + 1);
        exp_ptr = (w + r - ((w == 0 && r > 0) ? 1 : 0)) % 8;
        rd(4'hD, v);
        check("R7 final pointer", v[2:0], exp_ptr);
        check("R8 speed readback", v[5:4], spd);
        rd(4'h1, v);
        check("R2 count kept", v, r * 16 + w);
        rd(4'h0, v);
        check("R9 opcode kept", v, opc);
        wr(4'h2, 8'h10);
        for (int i = 0; i < w; i++) begin
            rd(4'hC, v);
            check("R4 outbound slot", v, wpat(i, w, r));
        end
        for (int j = (w == 0) ? 1 : 0; j < r; j++) begin
            rd(4'hC, v);
            check("R6 captured byte", v, resp(1 + w + j));
        end
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'h0, v); check("R10 opcode reset", v, 8'h00);
        rd(4'h1, v); check("R10 count reset", v, 8'h00);
        rd(4'h2, v); check("R10 ctrl reset", v, 8'h00);
        rd(4'hD, v); check("R10 status reset", v, 8'h30);
        check("R10 cs idle", spi_cs_n, 1);
        check("R10 sclk idle", spi_sclk, 0);
        // R4 wrap: nine data writes land pointer at 1
        wr(4'h2, 8'h10);
        for (int i = 0; i < 9; i++) wr(4'hC, 8'(i));
        rd(4'hD, v); check("R4 pointer wrap", v[2:0], 1);
        for (int w = 0; w < 4; w++)
            for (int r = 0; r < 5; r++)
                run(w, r, ((w + r) % 4), (w == 2 && r == 3));
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule